// File: doc/BRIEF.md
# Page Read Scan Register

This block is a test-access data register that streams a whole memory page out on the serial test data output. It has only an 8-bit shift register, but from the outside it behaves like a long scan chain. While the register is selected and the controller sits in the shift state, it counts shift clocks. On every eighth clock it pulls the next byte from an external page buffer into the shift register, and the read address moves forward by one. The capture state does not load any data. Instead, the first eight shifted bits are padding, which covers the time needed to fetch the first byte. The visible chain is therefore one page plus eight bits long: 1032 bits for a 128-byte page.

The block is clocked by the test clock and is driven by the instruction code and by the capture and shift state decodes from a test-access controller. The page buffer reads asynchronously: `rd_data` must be valid for `rd_addr` in the same cycle that `rd_en` is high. Serial input is never used for page data. Page streaming only gives meaningful data when this device is the first one in the scan chain.

Top module: `pgrd_scan_reg`

## Requirements
- R1: The register is selected only while `ir_code` (4 bits) equals 0x7. With any other code, shifting has no effect: `rd_en` stays low and `rd_addr` keeps its value.
- R2: A capture cycle while selected clears the bit position and the read address to 0 (`rd_addr`==0 after the edge). It loads no page data.
- R3: Counting shift edges from the last clear as 0,1,2,…, edge number k with k mod 8 = 7 is a fetch. In the cycle before that edge, `rd_en` is high for exactly one cycle and `rd_addr` = (k div 8) mod 128. After the fetch edge, the address is one higher, wrapping from 127 to 0.
- R4: Output bit j (the `tdo` value seen before shift edge j) is padding for j<8. For j≥8 it equals bit (j-8) mod 8 of page byte ((j-8) div 8) mod 128. Each byte goes out least significant bit first.
- R5: The page-data bits on `tdo` do not depend on `tdi` in any way.
- R6: When `ir_code` changes to 0x7 from another value, the first edge clears the bit position and the address, exactly as a capture does. That edge does not count as a shift edge.
- R7: A selected cycle with neither capture nor shift holds the address and the bit position. Shifting then resumes from the same point.
- R8: The chain is circular. After the 1032-bit chain, further shifting continues with page byte 0 again, with no new padding.
- R9: While the register is not selected, `tdo` is 0.
- R10: After a synchronous active-low reset, `rd_addr` is 0, `rd_en` is 0 and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_code | input | 4 | Current instruction code; 0x7 selects this register |
| capture_dr | input | 1 | Controller is in the capture state |
| shift_dr | input | 1 | Controller is in the shift state |
| tdi | input | 1 | Serial data in; never reaches the page data |
| rd_data | input | 8 | Page buffer read data for `rd_addr`, combinational |
| rd_addr | output | 7 | Page buffer byte address |
| rd_en | output | 1 | Fetch strobe: the byte at `rd_addr` is taken at the next edge |
| tdo | output | 1 | Serial data out |

## Verification
The cases hardest to reach from the ports are the address wrap and the circular restart. They only show up after more than a thousand uninterrupted shift clocks, so one scenario shifts past the full chain length and compares every bit against a model that works from bit position alone. The other awkward cases are a reselection or a capture in the middle of a byte, and a pause in shifting. The bench drives these by dropping and restoring the instruction code, asserting capture, or lowering the shift decode at odd bit counts. All the while, a reference model is compared against `rd_en`, `rd_addr` and `tdo` on every clock, with random serial input.

// File: rtl/pgrd_pkg.sv
// Shared constants and types for the page read scan register.
// Assumes a 4-bit instruction register; opcode 0x7 selects the block.
package pgrd_pkg;
    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] PGRD_OPCODE = 4'h7;

    // Per-cycle control strobes produced by the sequencer.
    typedef struct packed {
        logic clr;    // clear position and address at this edge
        logic step;   // a counted shift edge
        logic fetch;  // this step reloads the shift register
    } pgrd_ctl_t;
endpackage

// File: rtl/pgrd_seq.sv
// Bit-position sequencer: tracks the position inside the current byte and
// turns selection, capture and shift decodes into clear/step/fetch strobes.
// Assumes capture and shift decodes are never high together.
module pgrd_seq
    import pgrd_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int BIT_W = $clog2(BYTE_W)
) (
    input  logic      tck,
    input  logic      rst_n,
    input  logic      sel,
    input  logic      capture_dr,
    input  logic      shift_dr,
    output pgrd_ctl_t ctl
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic [BIT_W-1:0] bit_pos;
    logic             sel_q;

    // Decode strobes; a clear masks the shift on the same edge.
    always_comb begin
        ctl.clr   = sel && (capture_dr || !sel_q);
        ctl.step  = sel && shift_dr && !ctl.clr;
        ctl.fetch = ctl.step && (bit_pos == LAST_BIT);
    end

    // Track previous selection and the bit position within a byte.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            bit_pos <= '0;
        end else begin
            sel_q <= sel;
            if (ctl.clr) begin
                bit_pos <= '0;
            end else if (ctl.step) begin
                bit_pos <= (bit_pos == LAST_BIT) ? '0 : bit_pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pgrd_addr.sv
// Page byte address counter: cleared by the sequencer, advanced on fetch,
// wrapping after the last byte of the page.
module pgrd_addr #(
    parameter int PAGE_BYTES = 128,
    localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fetch,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PAGE_BYTES - 1);

    // Clear, hold or advance the byte address.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (fetch) begin
            addr <= (addr == LAST_ADDR) ? '0 : addr + 1'b1;
        end
    end
endmodule

// File: rtl/pgrd_shifter.sv
// Byte-wide shift register: parallel load from the page buffer on fetch,
// otherwise shifts toward bit 0. The fill bit enters at the top and is
// always overwritten by the next load before it reaches bit 0 of page data.
module pgrd_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              step,
    input  logic              fetch,
    input  logic              fill,
    input  logic [BYTE_W-1:0] load_data,
    output logic              ser_out
);
    logic [BYTE_W-1:0] sreg;

    // Load on fetch, shift right on any other counted step.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (fetch) begin
            sreg <= load_data;
        end else if (step) begin
            sreg <= {fill, sreg[BYTE_W-1:1]};
        end
    end

    assign ser_out = sreg[0];
endmodule

// File: rtl/pgrd_scan_reg.sv
// Top of the page read scan register. Presents a chain of one page plus one
// byte of padding using a single byte of storage, fetching page bytes from
// an asynchronous-read page buffer during shifting.
// Assumes rd_data is valid for rd_addr within the same cycle.
module pgrd_scan_reg
    import pgrd_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              tdi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    output logic              tdo
);
    logic      sel;
    logic      ser_bit;
    pgrd_ctl_t ctl;

    // Instruction decode for this register.
    assign sel = (ir_code == PGRD_OPCODE);

    pgrd_seq #(.BYTE_W(BYTE_W)) u_seq (
        .tck        (tck),
        .rst_n      (rst_n),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .ctl        (ctl)
    );

    pgrd_addr #(.PAGE_BYTES(PAGE_BYTES)) u_addr (
        .tck   (tck),
        .rst_n (rst_n),
        .clr   (ctl.clr),
        .fetch (ctl.fetch),
        .addr  (rd_addr)
    );

    pgrd_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .tck       (tck),
        .rst_n     (rst_n),
        .step      (ctl.step),
        .fetch     (ctl.fetch),
        .fill      (tdi),
        .load_data (rd_data),
        .ser_out   (ser_bit)
    );

    // Output strobe and gated serial output.
    assign rd_en = ctl.fetch;
    assign tdo   = sel && ser_bit;
endmodule

// File: rtl/pgrd_scan_reg_chk.sv
// Temporal checks on the page read scan register ports, bound to the top.
module pgrd_scan_reg_chk
    import pgrd_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
    input logic              tck,
    input logic              rst_n,
    input logic [IR_W-1:0]   ir_code,
    input logic              capture_dr,
    input logic              shift_dr,
    input logic [BYTE_W-1:0] rd_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_en,
    input logic              tdo
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(PAGE_BYTES - 1);

    logic chk_sel;
    assign chk_sel = (ir_code == PGRD_OPCODE);

    // R3: each fetch advances the address by one, wrapping at the page end.
    p_addr_step_r3: assert property (@(posedge tck) disable iff (!rst_n)
        rd_en |=> rd_addr == (($past(rd_addr) == TOP_ADDR) ? '0 : $past(rd_addr) + 1'b1));

    // R3: the fetch strobe lasts a single cycle.
    p_fetch_single_r3: assert property (@(posedge tck) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R2: capture while selected clears the address.
    p_capture_clear_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (chk_sel && capture_dr) |=> (rd_addr == '0));

    // R6: a new selection clears the address.
    p_reselect_clear_r6: assert property (@(posedge tck) disable iff (!rst_n)
        (chk_sel && !$past(chk_sel)) |=> (rd_addr == '0));

    // R7: an idle selected cycle holds the address.
    p_idle_hold_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (chk_sel && $past(chk_sel) && !capture_dr && !shift_dr) |=> $stable(rd_addr));

    // R4: a fetched byte shows its least significant bit first.
    p_lsb_first_r4: assert property (@(posedge tck) disable iff (!rst_n)
        rd_en |=> (!chk_sel || (tdo == $past(rd_data[0]))));
endmodule

bind pgrd_scan_reg pgrd_scan_reg_chk #(
    .PAGE_BYTES (PAGE_BYTES),
    .BYTE_W     (BYTE_W)
) u_chk (
    .tck        (tck),
    .rst_n      (rst_n),
    .ir_code    (ir_code),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .rd_en      (rd_en),
    .tdo        (tdo)
);

// File: tb/pgrd_scan_reg_tb.sv
// Bench: behavioural bit-position model compared with the outputs every clock.
module pgrd_scan_reg_tb;
    localparam int PAGE  = 128;
    localparam int CHAIN = PAGE * 8 + 8;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ir_code = 4'h0;
    logic       capture_dr = 1'b0;
    logic       shift_dr = 1'b0;
    logic       tdi = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] rd_addr;
    logic       rd_en;
    logic       tdo;

    logic [7:0] mem [PAGE];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pos = 0;
    bit prev_sel = 1'b0;
    bit running = 1'b0;
    string phase_tag = "R4";

    always #5 tck = ~tck;

    assign rd_data = mem[rd_addr];

    pgrd_scan_reg u_dut (
        .tck(tck), .rst_n(rst_n), .ir_code(ir_code), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .tdi(tdi), .rd_data(rd_data), .rd_addr(rd_addr),
        .rd_en(rd_en), .tdo(tdo)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model: shift-edge position since the last clear.
    always @(posedge tck) begin
        bit s, c;
        cyc++;
        if (!rst_n) begin
            pos = 0;
            prev_sel = 1'b0;
        end else begin
            s = (ir_code == 4'h7);
            c = s && (capture_dr || !prev_sel);
            if (c) pos = 0;
            else if (s && shift_dr) pos++;
            prev_sel = s;
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge tck) begin
        bit s, c;
        int idx, bn;
        if (rst_n && running) begin
            s = (ir_code == 4'h7);
            c = s && (capture_dr || !prev_sel);
            chk("R3 rd_en", 32'(rd_en), 32'(s && shift_dr && !c && (pos % 8 == 7)));
            chk(s ? "R3 rd_addr" : "R1 rd_addr", 32'(rd_addr), 32'((pos / 8) % PAGE));
            if (!s) begin
                chk("R9 tdo", 32'(tdo), 32'd0);
            end else if (!c && pos >= 8) begin
                idx = ((pos - 8) / 8) % PAGE;
                bn  = (pos - 8) % 8;
                chk(pos >= CHAIN ? "R8 tdo" : phase_tag, 32'(tdo), 32'(mem[idx][bn]));
            end
        end
    end

    task automatic tick();
        @(posedge tck);
        #2;
    endtask

    task automatic shift_bits(int n, bit rnd);
        for (int i = 0; i < n; i++) begin
            shift_dr = 1'b1;
            tdi = rnd ? 1'($urandom) : 1'b0;
            tick();
        end
        shift_dr = 1'b0;
    endtask

    task automatic capture();
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < PAGE; i++) mem[i] = 8'((i * 37 + 11) ^ (i << 3));
        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge tck);
        chk("R10 rd_addr", 32'(rd_addr), 32'd0);
        chk("R10 rd_en", 32'(rd_en), 32'd0);
        chk("R10 tdo", 32'(tdo), 32'd0);
        running = 1'b1;
        tick();

        // R1: wrong instruction code, shifting does nothing.
        ir_code = 4'h3;
        shift_bits(20, 1'b1);

        // R4 and R8: full chain plus wrap.
        ir_code = 4'h7;
        tick();
        capture();
        @(negedge tck);
        chk("R2 rd_addr after capture", 32'(rd_addr), 32'd0);
        tick();
        phase_tag = "R4 tdo";
        shift_bits(CHAIN + 24, 1'b0);

        // R5: random serial input during a page read.
        capture();
        phase_tag = "R5 tdo";
        shift_bits(300, 1'b1);

        // R7: pause mid-byte and resume.
        capture();
        phase_tag = "R7 tdo";
        shift_bits(21, 1'b1);
        repeat (5) tick();
        shift_bits(30, 1'b1);

        // R6: deselect and reselect mid-byte without capture.
        ir_code = 4'h2;
        repeat (3) tick();
        ir_code = 4'h7;
        phase_tag = "R6 tdo";
        shift_bits(40, 1'b1);

        // R2: capture in the middle of a byte.
        shift_bits(13, 1'b1);
        capture();
        @(negedge tck);
        chk("R2 rd_addr mid-byte capture", 32'(rd_addr), 32'd0);
        tick();
        phase_tag = "R2 tdo";
        shift_bits(30, 1'b1);

        ir_code = 4'h0;
        repeat (4) tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule